// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked system and an external 256K x 8 asynchronous static RAM. The host issues one word per request over a valid/ready handshake. Each request carries an 18-bit word address, a write flag and 8 bits of write data. The controller then produces the memory strobes in a fixed, cycle-counted order:

- address,
- an active-low and an active-high chip enable,
- write enable,
- output enable,
- outgoing data and its driver enable.

Read data comes back to the host together with a one-cycle valid pulse.

Every minimum time is given in nanoseconds and turned into a cycle count at elaboration. Each count is the ceiling of the minimum divided by the clock-period parameter, with a floor of one cycle. A write has three phases: a turnaround with output enable high, a write-enable pulse with data driven, and one hold cycle with data still driven. A read keeps output enable low for the access window and samples the data pins on the last cycle of that window.

Top module: `sram_async_ctl`

## Requirements
- R1: The memory is selected (mem_ce1_n = 0 and mem_ce2 = 1) only while an access is in progress. Whenever req_ready is high, mem_ce1_n = 1 and mem_ce2 = 0.
- R2: mem_we_n is low only while the chip is selected and mem_oe_n is high. mem_oe_n is low only while the chip is selected and mem_we_n is high.
- R3: mem_addr changes only in a cycle where mem_we_n is high both before and after the change.
- R4: A write holds mem_we_n low for at least ceil(35 ns / period) cycles. The chip must be selected with a stable address for at least ceil(70 ns / period) cycles before mem_we_n rises.
- R5: mem_dout_en is high with mem_dout stable for at least ceil(30 ns / period) cycles before mem_we_n rises. It stays high for one further cycle after the rise, and the written byte is the request's data.
- R6: mem_dout_en rises only after mem_oe_n has been high for at least ceil(30 ns / period) cycles, and it is never high while mem_oe_n is low.
- R7: A read keeps mem_oe_n low for ceil(max(70, 35) ns / period) cycles. It then returns the sampled byte on rd_data with rd_valid high for exactly one cycle. That cycle is the same number of cycles after the accept edge.
- R8: After reset, mem_ce1_n = 1, mem_ce2 = 0, mem_we_n = 1, mem_oe_n = 1, mem_dout_en = 0, rd_valid = 0 and req_ready = 1.
- R9: req_ready is high only when the controller is idle. A request raised while req_ready is low has no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Read data |
| mem_addr | output | 18 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dout | output | 8 | Data toward the memory |
| mem_dout_en | output | 1 | Driver enable for mem_dout |
| mem_din | input | 8 | Data from the memory |

## Verification
At the 20 ns default period, a write accepted on edge E selects the chip at E and pulls mem_we_n low at E+2. mem_we_n rises at E+4 and the driver drops at E+5. A read lowers mem_oe_n at E and samples on edge E+4, so rd_valid is seen in the cycle after E+4. The bench memory model only presents correct data once output enable has been low for the full access window, so a design that samples early reads a wrong byte. A scoreboard compares each read against the bench's own copy of memory and checks the accept-to-valid distance. A monitor samples at the falling edge and measures pulse, setup, hold and turnaround lengths as run counts of the observed strobes.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    // ceiling of ns / period, never below one cycle
    function automatic int cycles_for(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_W_TURN,
        PH_W_PULSE,
        PH_W_HOLD,
        PH_R_ACCESS
    } phase_e;

    // active-high strobe set, inverted at the pins where needed
    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
        logic drv;
    } strobe_t;

    function automatic strobe_t strobes_for(input phase_e p);
        strobe_t s;
        s = '0;
        case (p)
            PH_W_TURN:   s.sel = 1'b1;
            PH_W_PULSE:  begin s.sel = 1'b1; s.wr = 1'b1; s.drv = 1'b1; end
            PH_W_HOLD:   begin s.sel = 1'b1; s.drv = 1'b1; end
            PH_R_ACCESS: begin s.sel = 1'b1; s.rd = 1'b1; end
            default:     s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= capture;
            if (capture)
                data <= din;
        end
    end
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_WP_NS       = 35,
    parameter int T_DW_NS       = 30,
    parameter int T_AW_NS       = 70,
    parameter int T_WC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_OE_NS       = 35,
    parameter int T_REL_NS      = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int N_REL    = cycles_for(T_REL_NS, CLK_PERIOD_NS);
    localparam int N_WP_MIN = max_of(cycles_for(T_WP_NS, CLK_PERIOD_NS),
                                     cycles_for(T_DW_NS, CLK_PERIOD_NS));
    localparam int N_AW_REM = cycles_for(T_AW_NS, CLK_PERIOD_NS) - N_REL;
    localparam int N_WC_REM = cycles_for(T_WC_NS, CLK_PERIOD_NS) - N_REL - 1;
    localparam int N_PULSE  = max_of(N_WP_MIN, max_of(N_AW_REM, N_WC_REM));
    localparam int N_RD     = max_of(cycles_for(T_AA_NS, CLK_PERIOD_NS),
                                     cycles_for(T_OE_NS, CLK_PERIOD_NS));
    localparam int N_MAX    = max_of(N_REL, max_of(N_PULSE, N_RD));
    localparam int CNT_W    = (N_MAX < 2) ? 1 : $clog2(N_MAX);

    phase_e            state_q, state_d;
    strobe_t           strobe_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              tmr_load, tmr_done, capture, accept;
    logic [CNT_W-1:0]  tmr_val;

    assign req_ready = (state_q == PH_IDLE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (state_q)
            PH_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = PH_W_TURN;
                        tmr_val = CNT_W'(N_REL - 1);
                    end else begin
                        state_d = PH_R_ACCESS;
                        tmr_val = CNT_W'(N_RD - 1);
                    end
                end
            end
            PH_W_TURN: begin
                if (tmr_done) begin
                    state_d  = PH_W_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_PULSE - 1);
                end
            end
            PH_W_PULSE: if (tmr_done) state_d = PH_W_HOLD;
            PH_W_HOLD:  state_d = PH_IDLE;
            PH_R_ACCESS: begin
                if (tmr_done) begin
                    capture = 1'b1;
                    state_d = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PH_IDLE;
            strobe_q <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else begin
            state_q  <= state_d;
            strobe_q <= strobes_for(state_d);
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    sram_cycle_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_read_capture #(.DATA_W(DATA_W)) capture_i (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .din     (mem_din),
        .valid   (rd_valid),
        .data    (rd_data)
    );

    assign mem_addr    = addr_q;
    assign mem_dout    = wdata_q;
    assign mem_ce1_n   = ~strobe_q.sel;
    assign mem_ce2     = strobe_q.sel;
    assign mem_we_n    = ~strobe_q.wr;
    assign mem_oe_n    = ~strobe_q.rd;
    assign mem_dout_en = strobe_q.drv;
endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_WP_NS       = 35,
    parameter int T_REL_NS      = 30
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dout_en
);
    localparam int C_WP  = cycles_for(T_WP_NS, CLK_PERIOD_NS);
    localparam int C_REL = cycles_for(T_REL_NS, CLK_PERIOD_NS);

    logic [7:0] we_low_q, oe_high_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_q  <= '0;
            oe_high_q <= 8'hFF;
        end else begin
            we_low_q  <= !mem_we_n ? ((we_low_q == 8'hFF) ? we_low_q : we_low_q + 1'b1) : 8'd0;
            oe_high_q <= mem_oe_n ? ((oe_high_q == 8'hFF) ? oe_high_q : oe_high_q + 1'b1) : 8'd0;
        end
    end

    // R1
    idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce1_n && !mem_ce2));

    // R2
    write_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && !mem_ce1_n && mem_ce2));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> $stable(mem_addr));

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_q >= 8'(C_WP)));

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> mem_oe_n);

    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dout_en) |-> (oe_high_q >= 8'(C_REL)));

    // R7
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

bind sram_async_ctl sram_async_ctl_chk #(
    .ADDR_W(ADDR_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .T_WP_NS(T_WP_NS), .T_REL_NS(T_REL_NS)
) chk_i (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout_en(mem_dout_en)
);

// File: tb/sram_async_ctl_tb_top.sv
module sram_async_ctl_tb_top;
    localparam int P      = 20;
    localparam int E_WP   = (35 + P - 1) / P;
    localparam int E_DW   = (30 + P - 1) / P;
    localparam int E_AW   = (70 + P - 1) / P;
    localparam int E_REL  = (30 + P - 1) / P;
    localparam int E_RD   = (70 + P - 1) / P;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rd_valid, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dout_en;
    logic [7:0]  rd_data, mem_dout;
    logic [7:0]  mem_din = 8'hA5;
    logic [17:0] mem_addr;

    always #10 clk = ~clk;

    sram_async_ctl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    int checks = 0, errs = 0, cyc = 0;
    bit finished = 0;
    logic [7:0] model [logic [17:0]];
    logic [7:0] shadow [logic [17:0]];
    logic [7:0] exp_q [$];
    int         acc_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model and strobe monitor, all sampled at the falling edge
    logic [17:0] prev_addr = '0;
    logic [7:0]  prev_dout = '0;
    logic prev_we_n = 1'b1, prev_den = 1'b0, prev_rv = 1'b0;
    int we_low = 0, drv_run = 0, oe_high = 100, oe_low = 0, sel_run = 0;

    always @(negedge clk) if (!rst) begin
        automatic bit sel = !mem_ce1_n && mem_ce2;
        if (mem_addr != prev_addr)
            check(mem_we_n && prev_we_n, "R3 addr change with we_n low", mem_we_n, 1);
        if (!mem_we_n)
            check(sel && mem_oe_n, "R2 write strobes", {sel, mem_oe_n}, 3);
        if (!mem_oe_n)
            check(sel && mem_we_n, "R2 read strobes", {sel, mem_we_n}, 3);
        if (req_ready)
            check(!sel, "R1 selected while idle", sel, 0);
        if (mem_dout_en && !prev_den)
            check(oe_high >= E_REL, "R6 turnaround", oe_high, E_REL);
        if (mem_dout_en)
            check(mem_oe_n, "R6 contention", mem_oe_n, 1);
        if (prev_rv)
            check(!rd_valid, "R7 rd_valid pulse width", rd_valid, 0);
        if (mem_we_n && !prev_we_n) begin
            check(we_low >= E_WP, "R4 write pulse", we_low, E_WP);
            check(sel_run >= E_AW, "R4 address to end of write", sel_run, E_AW);
            check(drv_run >= E_DW, "R5 data setup", drv_run, E_DW);
            check(mem_dout_en, "R5 data hold", mem_dout_en, 1);
            if (sel) model[mem_addr] = mem_dout;
        end
        we_low  = !mem_we_n ? we_low + 1 : 0;
        drv_run = (mem_dout_en && (mem_dout == prev_dout || !prev_den)) ? drv_run + 1
                : (mem_dout_en ? 1 : 0);
        oe_high = mem_oe_n ? oe_high + 1 : 0;
        oe_low  = (!mem_oe_n && sel && mem_we_n) ? oe_low + 1 : 0;
        sel_run = (sel && mem_addr == prev_addr) ? sel_run + 1 : (sel ? 1 : 0);
        if (oe_low >= E_RD)
            mem_din = model.exists(mem_addr) ? model[mem_addr] : 8'hC3;
        else
            mem_din = 8'hA5;
        prev_addr = mem_addr; prev_dout = mem_dout; prev_we_n = mem_we_n;
        prev_den = mem_dout_en; prev_rv = rd_valid;
    end

    // scoreboard monitor
    always @(negedge clk) if (!rst && rd_valid) begin
        if (exp_q.size() == 0) begin
            check(0, "R7 unexpected rd_valid", rd_data, 0);
        end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic int a = acc_q.pop_front();
            check(rd_data == e, "R7 read data", rd_data, e);
            check(cyc - a == E_RD, "R7 read latency", cyc - a, E_RD);
        end
    end

    task automatic issue(input bit wr, input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!wr) acc_q.push_back(cyc);
    endtask

    task automatic do_write(input logic [17:0] a, input logic [7:0] d);
        shadow[a] = d;
        issue(1'b1, a, d);
    endtask

    task automatic do_read(input logic [17:0] a);
        exp_q.push_back(shadow[a]);
        issue(1'b0, a, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(mem_ce1_n && !mem_ce2, "R8 chip enables", {mem_ce1_n, mem_ce2}, 2);
        check(mem_we_n && mem_oe_n, "R8 we_n/oe_n", {mem_we_n, mem_oe_n}, 3);
        check(!mem_dout_en && !rd_valid, "R8 driver/valid", {mem_dout_en, rd_valid}, 0);
        check(req_ready, "R8 ready", req_ready, 1);

        do_write(18'h00000, 8'h00);
        do_write(18'h3FFFF, 8'hFF);
        do_write(18'h15555, 8'hA5);
        do_write(18'h2AAAA, 8'h5A);
        do_read(18'h3FFFF);
        do_read(18'h00000);
        do_read(18'h15555);
        do_write(18'h15555, 8'h3C);
        do_read(18'h15555);
        do_read(18'h2AAAA);

        // R9: request raised while busy is ignored
        do_write(18'h01234, 8'h81);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h2AAAA; req_wdata = 8'hEE;
        for (int i = 0; i < 2; i++) begin
            check(!req_ready, "R9 ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        do_read(18'h2AAAA);
        do_read(18'h01234);

        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errs++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule